// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Loader

This block receives configuration words for a dual-loop frequency synthesizer over a three-wire serial link (serial clock, serial data and load strobe). All three lines are sampled by the on-chip system clock through synchronizers. Every rising edge of the serial clock pushes one data bit into a single 23-bit shift register, most significant bit first. A rising edge of the load strobe copies the top 21 bits of that register into one of four destination latches. The destination is picked by the two lowest bits of the word.

The four latches hold the transmit reference word, the transmit main-divider word, the receive reference word and the receive main-divider word. A latch refuses a word whose divider count is below the legal minimum of 3, and keeps its previous contents in that case.

The block also decodes three flags from the reference words: a charge-pump high-current select for each side, and an output-source select taken from the transmit reference word. The output-source select steers a shared status pin. It carries either the lock indication or the phase-comparator monitor signal.

Top module: `sercfg_loader`

## Requirements
- R1: Synchronous active-low reset clears all four latched words and the three flags to 0. With the flags at 0, `ld_fout_o` follows `lock_det_i`.
- R2: Bits enter MSB first. After 23 serial clock rises and a load strobe, the addressed latch holds the first 21 bits sent, with the first bit sent as latch bit 20.
- R3: Word bits [1:0] select the destination: 0 = transmit reference, 1 = transmit main, 2 = receive reference, 3 = receive main. Only the addressed latch may change on a load.
- R4: Serial clock rises with no load-strobe rise leave all latched words and flags unchanged.
- R5: A reference word carries its divider count in payload bits [13:0] (word bits [15:2]). The word is loaded only when that count is 3 or more; counts 3 and 16383 are accepted and counts 0 to 2 are refused.
- R6: A main word carries a swallow count in payload [6:0] and a program count in payload [17:7]. The word is loaded only when the program count is 3 or more; swallow counts 0 and 127 are both accepted.
- R7: `ld_sel_o` equals bit 15 of the transmit reference latch (word bit 17). `ld_fout_o` carries `pd_mon_i` when this flag is 1 and `lock_det_i` when it is 0. Bit 15 of the receive reference latch has no effect on the flag.
- R8: `tx_cp_high_o` and `rx_cp_high_o` equal bit 14 (word bit 16) of the transmit and receive reference latches.
- R9: A serial clock rise and a load-strobe rise that reach the block in the same cycle load the word that includes the bit shifted in that cycle.
- R10: Only a rising edge of the load strobe loads. Holding the strobe high while shifting, and then releasing it, loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe; rising edge loads |
| lock_det_i | input | 1 | Lock indication to route to the status pin |
| pd_mon_i | input | 1 | Phase-comparator monitor to route to the status pin |
| tx_ref_word_o | output | 21 | Transmit reference latch |
| tx_main_word_o | output | 21 | Transmit main-divider latch |
| rx_ref_word_o | output | 21 | Receive reference latch |
| rx_main_word_o | output | 21 | Receive main-divider latch |
| tx_cp_high_o | output | 1 | Transmit charge-pump high-current select |
| rx_cp_high_o | output | 1 | Receive charge-pump high-current select |
| ld_sel_o | output | 1 | Status-pin source select |
| ld_fout_o | output | 1 | Shared status pin |

## Verification
The shift of one bit and the load of the word can happen in the same system cycle. This occurs when the serial clock and the load strobe rise together. The bench sets up this case by sending 22 bits, placing the last data bit, and then raising both lines on the same clock edge. It judges the result by whether the latch holds the full 23-bit word rather than the word one bit short. A second overlap is a load strobe held high across a complete new word. For that case the bench checks that neither the shifting nor the strobe's fall loads anything.

// File: rtl/sercfg_pkg.sv
// Package: shared layout of the serial configuration word.
// Assumes a 23-bit word with a 2-bit destination code in the low bits.
package sercfg_pkg;
    localparam int WORD_W   = 23;
    localparam int ADDR_W   = 2;
    localparam int PAY_W    = WORD_W - ADDR_W;
    localparam int NUM_DEST = 1 << ADDR_W;

    // Destination codes carried in word bits [1:0]
    typedef enum logic [ADDR_W-1:0] {
        DST_TX_REF  = 2'd0,
        DST_TX_MAIN = 2'd1,
        DST_RX_REF  = 2'd2,
        DST_RX_MAIN = 2'd3
    } dest_e;

    // Reference word payload fields
    localparam int REF_LSB   = 0;
    localparam int REF_W     = 14;
    localparam int CP_BIT    = 14;
    localparam int LDSEL_BIT = 15;

    // Main word payload fields
    localparam int SWAL_LSB  = 0;
    localparam int SWAL_W    = 7;
    localparam int PROG_LSB  = 7;
    localparam int PROG_W    = 11;
    localparam int PRE_BIT   = 18;
endpackage

// File: rtl/sercfg_sync.sv
// Module: multi-bit synchronizer chain for asynchronous serial lines.
// Assumes each bit is independent and changes slowly against clk.
module sercfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe [STAGES];

    // Shift the raw inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= async_i;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/sercfg_shift.sv
// Module: shared serial shift register, MSB first.
// Assumes shift_en is a one-cycle pulse per serial clock rise.
// word_next shows the contents after this cycle's shift, so a load in the
// same cycle sees the new bit.
module sercfg_shift #(
    parameter int WORD_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_next
);
    logic [WORD_W-1:0] sr_q;

    // Next contents: shifted when a serial edge arrives, held otherwise
    always_comb begin
        word_next = shift_en ? {sr_q[WORD_W-2:0], bit_i} : sr_q;
    end

    // Register the shift result
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= word_next;
    end
endmodule

// File: rtl/sercfg_dest.sv
// Module: one destination latch.
// Captures the payload when a load strobe comes with this latch's code.
// Refuses a word whose divider field is below MIN_VAL.
module sercfg_dest #(
    parameter int WORD_W    = 23,
    parameter int ADDR_W    = 2,
    parameter int DEST      = 0,
    parameter int FIELD_LSB = 0,
    parameter int FIELD_W   = 14,
    parameter int MIN_VAL   = 3,
    localparam int PAY_W    = WORD_W - ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_stb,
    input  logic [WORD_W-1:0] word_i,
    output logic [PAY_W-1:0]  pay_o
);
    logic [PAY_W-1:0]   pay_in;
    logic [FIELD_W-1:0] field;
    logic               hit;
    logic               legal;

    // Split the word and judge address and divider range
    always_comb begin
        pay_in = word_i[WORD_W-1:ADDR_W];
        field  = pay_in[FIELD_LSB +: FIELD_W];
        hit    = (word_i[ADDR_W-1:0] == ADDR_W'(DEST));
        legal  = (field >= FIELD_W'(MIN_VAL));
    end

    // Latch the payload on an addressed, legal load
    always_ff @(posedge clk) begin
        if (!rst_n)                        pay_o <= '0;
        else if (load_stb && hit && legal) pay_o <= pay_in;
    end
endmodule

// File: rtl/sercfg_loader.sv
// Module: top of the three-wire configuration loader.
// Synchronizes the serial lines to clk, detects serial clock and load
// strobe rises, shifts into one register and loads one of four latches.
// Assumes the serial lines change no faster than every few clk cycles.
module sercfg_loader
    import sercfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REF_MIN     = 3,
    parameter int PROG_MIN    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk_i,
    input  logic             ser_data_i,
    input  logic             ser_le_i,
    input  logic             lock_det_i,
    input  logic             pd_mon_i,
    output logic [PAY_W-1:0] tx_ref_word_o,
    output logic [PAY_W-1:0] tx_main_word_o,
    output logic [PAY_W-1:0] rx_ref_word_o,
    output logic [PAY_W-1:0] rx_main_word_o,
    output logic             tx_cp_high_o,
    output logic             rx_cp_high_o,
    output logic             ld_sel_o,
    output logic             ld_fout_o
);
    localparam int LINES = 3;

    logic [LINES-1:0]  raw_lines;
    logic [LINES-1:0]  sync_lines;
    logic              sclk_s, sdata_s, sle_s;
    logic              sclk_q, sle_q;
    logic              sclk_rise, le_rise;
    logic [WORD_W-1:0] word_next;
    logic [PAY_W-1:0]  dest_pay [NUM_DEST];

    assign raw_lines = {ser_le_i, ser_data_i, ser_clk_i};

    sercfg_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_lines),
        .sync_o  (sync_lines)
    );

    assign {sle_s, sdata_s, sclk_s} = sync_lines;

    // Remember the previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sle_q  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            sle_q  <= sle_s;
        end
    end

    // Rising-edge pulses of serial clock and load strobe
    always_comb begin
        sclk_rise = sclk_s & ~sclk_q;
        le_rise   = sle_s & ~sle_q;
    end

    sercfg_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (sclk_rise),
        .bit_i     (sdata_s),
        .word_next (word_next)
    );

    // One latch per destination; even codes are reference words
    for (genvar g = 0; g < NUM_DEST; g++) begin : g_dest
        localparam bit IS_REF = (g % 2) == 0;
        sercfg_dest #(
            .WORD_W    (WORD_W),
            .ADDR_W    (ADDR_W),
            .DEST      (g),
            .FIELD_LSB (IS_REF ? REF_LSB : PROG_LSB),
            .FIELD_W   (IS_REF ? REF_W : PROG_W),
            .MIN_VAL   (IS_REF ? REF_MIN : PROG_MIN)
        ) u_dest (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_stb (le_rise),
            .word_i   (word_next),
            .pay_o    (dest_pay[g])
        );
    end

    assign tx_ref_word_o  = dest_pay[DST_TX_REF];
    assign tx_main_word_o = dest_pay[DST_TX_MAIN];
    assign rx_ref_word_o  = dest_pay[DST_RX_REF];
    assign rx_main_word_o = dest_pay[DST_RX_MAIN];

    // Decode flags and steer the shared status pin
    always_comb begin
        tx_cp_high_o = dest_pay[DST_TX_REF][CP_BIT];
        rx_cp_high_o = dest_pay[DST_RX_REF][CP_BIT];
        ld_sel_o     = dest_pay[DST_TX_REF][LDSEL_BIT];
        ld_fout_o    = ld_sel_o ? pd_mon_i : lock_det_i;
    end
endmodule

// File: rtl/sercfg_loader_chk.sv
// Module: assertion checker bound to sercfg_loader.
// Watches the latched outputs against the internal load pulse.
module sercfg_loader_chk
    import sercfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             le_rise,
    input logic [PAY_W-1:0] tx_ref,
    input logic [PAY_W-1:0] tx_main,
    input logic [PAY_W-1:0] rx_ref,
    input logic [PAY_W-1:0] rx_main,
    input logic             tx_cp,
    input logic             rx_cp,
    input logic             ld_sel
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (tx_ref == '0 && tx_main == '0 && rx_ref == '0
                           && rx_main == '0 && !ld_sel && !tx_cp && !rx_cp));

    assert_single_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_ref != $past(tx_ref), tx_main != $past(tx_main),
                  rx_ref != $past(rx_ref), rx_main != $past(rx_main)}));

    assert_hold_no_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> ($stable(tx_ref) && $stable(tx_main)
                      && $stable(rx_ref) && $stable(rx_main)));

    assert_ref_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ref[REF_W-1:0] inside {14'd1, 14'd2})
        && !(rx_ref[REF_W-1:0] inside {14'd1, 14'd2}));

    assert_prog_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_main[PROG_LSB +: PROG_W] inside {11'd1, 11'd2})
        && !(rx_main[PROG_LSB +: PROG_W] inside {11'd1, 11'd2}));

    assert_ldsel_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ld_sel) |-> $past(le_rise));

    assert_cp_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tx_cp) || !$stable(rx_cp)) |-> $past(le_rise));
endmodule

bind sercfg_loader sercfg_loader_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .le_rise (le_rise),
    .tx_ref  (tx_ref_word_o),
    .tx_main (tx_main_word_o),
    .rx_ref  (rx_ref_word_o),
    .rx_main (rx_main_word_o),
    .tx_cp   (tx_cp_high_o),
    .rx_cp   (rx_cp_high_o),
    .ld_sel  (ld_sel_o)
);

// File: tb/sercfg_loader_bench.sv
// Directed bench for sercfg_loader; one task per scenario.
module sercfg_loader_bench;
    localparam int PW = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic lock_det = 1'b0, pd_mon = 1'b0;
    logic [PW-1:0] tx_ref, tx_main, rx_ref, rx_main;
    logic tx_cp, rx_cp, ld_sel, ld_fout;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [PW-1:0] exp_w [4];

    always #10 clk = ~clk;

    sercfg_loader u_sercfg_loader (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk), .ser_data_i(ser_data), .ser_le_i(ser_le),
        .lock_det_i(lock_det), .pd_mon_i(pd_mon),
        .tx_ref_word_o(tx_ref), .tx_main_word_o(tx_main),
        .rx_ref_word_o(rx_ref), .rx_main_word_o(rx_main),
        .tx_cp_high_o(tx_cp), .rx_cp_high_o(rx_cp),
        .ld_sel_o(ld_sel), .ld_fout_o(ld_fout)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "tx_ref", 32'(tx_ref), 32'(exp_w[0]));
        chk(req, "tx_main", 32'(tx_main), 32'(exp_w[1]));
        chk(req, "rx_ref", 32'(rx_ref), 32'(exp_w[2]));
        chk(req, "rx_main", 32'(rx_main), 32'(exp_w[3]));
        chk(req, "tx_cp", 32'(tx_cp), 32'(exp_w[0][14]));
        chk(req, "rx_cp", 32'(rx_cp), 32'(exp_w[2][14]));
        chk(req, "ld_sel", 32'(ld_sel), 32'(exp_w[0][15]));
    endtask

    // Model of a load: address in bits [1:0], divider minimum of 3
    function automatic void model_load(logic [22:0] w);
        logic [PW-1:0] p = w[22:2];
        bit ok = (w[0] == 1'b0) ? (p[13:0] >= 14'd3) : (p[17:7] >= 11'd3);
        if (ok) exp_w[w[1:0]] = p;
    endfunction

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(logic b);
        ser_data = b;
        wait_clk(2);
        ser_clk = 1'b1;
        wait_clk(3);
        ser_clk = 1'b0;
        wait_clk(2);
    endtask

    task automatic shift_word(logic [22:0] w);
        for (int i = 22; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        wait_clk(4);
        ser_le = 1'b0;
        wait_clk(4);
    endtask

    task automatic send(logic [22:0] w);
        shift_word(w);
        pulse_le();
        model_load(w);
    endtask

    function automatic logic [22:0] rand_legal(logic [1:0] a);
        logic [PW-1:0] p = PW'($urandom);
        if (a[0] == 1'b0) p[13:0] = 14'(3 + ($urandom % 16381));
        else              p[17:7] = 11'(3 + ($urandom % 2045));
        return {p, a};
    endfunction

    task automatic test_reset();
        lock_det = 1'b1; pd_mon = 1'b0;
        wait_clk(1);
        check_all("R1");
        chk("R1", "ld_fout follows lock", 32'(ld_fout), 32'd1);
    endtask

    task automatic test_msb_first();
        logic [22:0] w = {21'h15A5C3, 2'd1};
        send(w);
        chk("R2", "tx_main exact", 32'(tx_main), 32'h15A5C3);
        check_all("R2");
    endtask

    task automatic test_addr_decode();
        for (int r = 0; r < 3; r++)
            for (int a = 0; a < 4; a++) begin
                send(rand_legal(2'(a)));
                check_all("R3");
            end
    endtask

    task automatic test_idle_shift();
        shift_word(rand_legal(2'd2));
        wait_clk(4);
        check_all("R4");
    endtask

    task automatic test_ref_limits();
        send({7'h00, 14'd2, 2'd0});
        check_all("R5");
        send({7'h00, 14'd3, 2'd0});
        chk("R5", "ref=3 accepted", 32'(tx_ref), 32'd3);
        send({7'h10, 14'd16383, 2'd2});
        chk("R5", "ref=16383 accepted", 32'(rx_ref[13:0]), 32'd16383);
        send({7'h00, 14'd1, 2'd2});
        check_all("R5");
        send({7'h00, 14'd0, 2'd0});
        check_all("R5");
    endtask

    task automatic test_main_limits();
        send({3'b000, 11'd2, 7'd5, 2'd1});
        check_all("R6");
        send({3'b100, 11'd3, 7'd127, 2'd1});
        chk("R6", "prog=3 swallow=127", 32'(tx_main), 32'({3'b100, 11'd3, 7'd127}));
        send({3'b000, 11'd2047, 7'd0, 2'd3});
        chk("R6", "prog=2047 swallow=0", 32'(rx_main), 32'({3'b000, 11'd2047, 7'd0}));
        send({3'b000, 11'd1, 7'd9, 2'd3});
        check_all("R6");
    endtask

    task automatic test_status_pin();
        send({5'b0, 1'b1, 1'b0, 14'd100, 2'd0});
        chk("R7", "ld_sel set", 32'(ld_sel), 32'd1);
        lock_det = 1'b0; pd_mon = 1'b1; wait_clk(1);
        chk("R7", "fout=pd 1", 32'(ld_fout), 32'd1);
        lock_det = 1'b1; pd_mon = 1'b0; wait_clk(1);
        chk("R7", "fout=pd 0", 32'(ld_fout), 32'd0);
        send({5'b0, 1'b0, 1'b0, 14'd100, 2'd2});
        send({5'b0, 1'b1, 1'b0, 14'd200, 2'd2});
        chk("R7", "rx bit15 ignored", 32'(ld_sel), 32'd1);
        send({5'b0, 1'b0, 1'b0, 14'd100, 2'd0});
        wait_clk(1);
        chk("R7", "fout=lock 1", 32'(ld_fout), 32'd1);
        lock_det = 1'b0; wait_clk(1);
        chk("R7", "fout=lock 0", 32'(ld_fout), 32'd0);
        check_all("R7");
    endtask

    task automatic test_cp();
        send({5'b0, 1'b0, 1'b1, 14'd50, 2'd0});
        send({5'b0, 1'b0, 1'b0, 14'd60, 2'd2});
        chk("R8", "tx_cp high", 32'(tx_cp), 32'd1);
        chk("R8", "rx_cp low", 32'(rx_cp), 32'd0);
        send({5'b0, 1'b0, 1'b0, 14'd50, 2'd0});
        send({5'b0, 1'b0, 1'b1, 14'd60, 2'd2});
        chk("R8", "tx_cp low", 32'(tx_cp), 32'd0);
        chk("R8", "rx_cp high", 32'(rx_cp), 32'd1);
    endtask

    task automatic test_same_cycle();
        logic [22:0] w = {3'b010, 11'd777, 7'd33, 2'd3};
        for (int i = 22; i >= 1; i--) shift_bit(w[i]);
        ser_data = w[0];
        wait_clk(2);
        ser_clk = 1'b1;
        ser_le  = 1'b1;
        wait_clk(4);
        ser_clk = 1'b0;
        ser_le  = 1'b0;
        wait_clk(4);
        model_load(w);
        chk("R9", "rx_main full word", 32'(rx_main), 32'(w[22:2]));
        check_all("R9");
    endtask

    task automatic test_le_held();
        send(rand_legal(2'd1));
        ser_le = 1'b1;
        wait_clk(4);
        shift_word({3'b001, 11'd400, 7'd1, 2'd1});
        ser_le = 1'b0;
        wait_clk(5);
        check_all("R10");
        pulse_le();
        model_load({3'b001, 11'd400, 7'd1, 2'd1});
        chk("R10", "loaded on next rise", 32'(tx_main), 32'({3'b001, 11'd400, 7'd1}));
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_w[i] = '0;
        wait_clk(4);
        test_reset();
        rst_n = 1'b1;
        wait_clk(2);
        test_reset();
        test_msb_first();
        test_addr_decode();
        test_idle_shift();
        test_ref_limits();
        test_main_limits();
        test_status_pin();
        test_cp();
        test_same_cycle();
        test_le_held();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule